// File: doc/BRIEF.md
# Master Clock Gate Wakeup Controller

This block owns the enable of a chip's master clock. Software stops the clock by writing a gate bit through a register write port, and starts it again by clearing that bit. Once the clock is stopped, software can no longer run, so the clock has to be released by hardware. Several wake sources do this: the two external interrupt pins, a wakeup pin, and an RTC event. When the clock is stopped there is no clock available to detect edges, so every wake source is sensed by its level. Any active wake source clears the gate bit at once, without waiting for a clock edge.

The write path runs on a free-running, always-on clock. The gate bit is cleared asynchronously by either the active-low reset or the combined wake condition. This gives wake a fixed priority over a disable request. A write that sets the gate bit has no effect while any wake condition is present. Software can read the gate bit back to see whether its request took effect. The wakeup pin can also serve as a general-purpose output. When its direction input says it is an output, its level is not treated as a wake source.

Top module: `mclk_gate_ctrl`

## Requirements
- R1: While `rst_ni` is low, and after it is released, the gate bit reads 0 and `clk_en_o` is 1.
- R2: A write (`wr_en_i`=1) with data bit 15 set, made when no wake condition is present, sets the gate bit at the next `clk_i` rising edge. After that edge `clk_en_o` is 0.
- R3: A write with data bit 15 clear clears the gate bit at the next rising edge. Every other data bit is ignored.
- R4: With `wr_en_i` low, the gate bit keeps its value across clock edges, whatever is on `wr_data_i`.
- R5: A low level on any bit of `int_n_i` clears the gate bit and raises `clk_en_o` without any `clk_i` edge.
- R6: A high level on `wake_pin_i` while `wake_dir_out_i`=0 (pin configured as input) clears the gate bit without any `clk_i` edge.
- R7: While `wake_dir_out_i`=1 (pin configured as output), the level of `wake_pin_i` has no effect on the gate bit. A disable write still takes effect with the pin high.
- R8: When `rtc_evt_i`=1 and `rtc_en_i`=1, the gate bit is cleared without any clock edge. When `rtc_en_i`=0, `rtc_evt_i` is ignored.
- R9: A write with data bit 15 set has no effect while any wake condition is present. The gate bit stays 0.
- R10: `gate_rd_o` always shows the current gate bit, and `clk_en_o` is its inverse.
- R11: Driving `rst_ni` low while the clock is gated clears the gate bit and raises `clk_en_o` at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running, always-on register clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe for the clock gating register |
| wr_data_i | input | 16 | Write data. Bit 15 is the gate request |
| rtc_evt_i | input | 1 | RTC alarm or periodic event, level |
| rtc_en_i | input | 1 | Enables the RTC event as a wake source |
| int_n_i | input | 2 | External interrupt pins, active low, level-sensed |
| wake_pin_i | input | 1 | Wakeup pin level, active high |
| wake_dir_out_i | input | 1 | 1: wakeup pin is an output, 0: input |
| clk_en_o | output | 1 | Master clock enable, 1 = clock runs |
| gate_rd_o | output | 1 | Readback of the gate bit |

## Verification
If the gate bit were left set while a wake source is active, `clk_en_o` would stay low. The chip would then never resume. This shows at the ports within a few nanoseconds of the wake level appearing, with no clock edge needed. A gate bit that drifts without a write shows at the readback one clock after the edge where it changed. A wrongly qualified wakeup pin shows in two ways: a gate request that cannot be made with the pin as an output, or a missed wake with the pin as an input.

// File: rtl/mcg_pkg.sv
package mcg_pkg;
  typedef enum logic {
    WPIN_IS_INPUT  = 1'b0,
    WPIN_IS_OUTPUT = 1'b1
  } wpin_dir_e;

  // wake pin counts only when it is sensed as an input
  function automatic logic wpin_qualify(input logic lvl, input wpin_dir_e dir);
    return lvl & (dir == WPIN_IS_INPUT);
  endfunction
endpackage

// File: rtl/mcg_wake_detect.sv
module mcg_wake_detect #(
  parameter int NUM_INT = 2
) (
  input  logic               rtc_evt_i,
  input  logic               rtc_en_i,
  input  logic [NUM_INT-1:0] int_n_i,
  input  logic               wake_pin_i,
  input  logic               wake_dir_out_i,
  output logic               wake_o
);
  import mcg_pkg::*;

  logic [NUM_INT-1:0] int_hit;
  logic               pin_hit;
  logic               rtc_hit;

  // level sensed: no clock is available while gated
  for (genvar g = 0; g < NUM_INT; g++) begin : g_int
    assign int_hit[g] = ~int_n_i[g];
  end

  assign pin_hit = wpin_qualify(wake_pin_i, wpin_dir_e'(wake_dir_out_i));
  assign rtc_hit = rtc_evt_i & rtc_en_i;
  assign wake_o  = (|int_hit) | pin_hit | rtc_hit;
endmodule

// File: rtl/mcg_gate_reg.sv
module mcg_gate_reg #(
  parameter int DATA_W   = 16,
  parameter int GATE_BIT = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wake_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              gate_o
);
  logic clr_n;
  logic gate_q;
  logic unused_data;

  // wake and reset share the async clear, so wake beats a set at any edge
  assign clr_n       = rst_ni & ~wake_i;
  assign unused_data = ^wr_data_i;

  always_ff @(posedge clk_i or negedge clr_n) begin
    if (!clr_n)       gate_q <= 1'b0;
    else if (wr_en_i) gate_q <= wr_data_i[GATE_BIT];
  end

  assign gate_o = gate_q;
endmodule

// File: rtl/mclk_gate_ctrl.sv
module mclk_gate_ctrl #(
  parameter int NUM_INT  = 2,
  parameter int DATA_W   = 16,
  parameter int GATE_BIT = 15
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic               rtc_evt_i,
  input  logic               rtc_en_i,
  input  logic [NUM_INT-1:0] int_n_i,
  input  logic               wake_pin_i,
  input  logic               wake_dir_out_i,
  output logic               clk_en_o,
  output logic               gate_rd_o
);
  logic wake;
  logic gate;

  mcg_wake_detect #(.NUM_INT(NUM_INT)) u_wake (
    .rtc_evt_i      (rtc_evt_i),
    .rtc_en_i       (rtc_en_i),
    .int_n_i        (int_n_i),
    .wake_pin_i     (wake_pin_i),
    .wake_dir_out_i (wake_dir_out_i),
    .wake_o         (wake)
  );

  mcg_gate_reg #(.DATA_W(DATA_W), .GATE_BIT(GATE_BIT)) u_gate (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wake_i    (wake),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .gate_o    (gate)
  );

  assign clk_en_o  = ~gate;
  assign gate_rd_o = gate;
endmodule

// File: rtl/mclk_gate_ctrl_chk.sv
module mclk_gate_ctrl_chk #(
  parameter int NUM_INT  = 2,
  parameter int DATA_W   = 16,
  parameter int GATE_BIT = 15
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_en_i,
  input logic [DATA_W-1:0]  wr_data_i,
  input logic               rtc_evt_i,
  input logic               rtc_en_i,
  input logic [NUM_INT-1:0] int_n_i,
  input logic               wake_pin_i,
  input logic               wake_dir_out_i,
  input logic               clk_en_o,
  input logic               gate_rd_o
);
  logic wake_seen;
  assign wake_seen = (~&int_n_i) | (wake_pin_i & ~wake_dir_out_i) | (rtc_evt_i & rtc_en_i);

  // R9
  wake_blocks_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_seen |-> !gate_rd_o);

  // R10
  en_inverse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_en_o == !gate_rd_o);

  // R2
  gate_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i[GATE_BIT] && !wake_seen) |=> (gate_rd_o || wake_seen));

  // R3
  gate_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_data_i[GATE_BIT]) |=> !gate_rd_o);

  // R4
  no_write_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> !$rose(gate_rd_o));
endmodule

bind mclk_gate_ctrl mclk_gate_ctrl_chk #(
  .NUM_INT(NUM_INT), .DATA_W(DATA_W), .GATE_BIT(GATE_BIT)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
  .rtc_evt_i(rtc_evt_i), .rtc_en_i(rtc_en_i), .int_n_i(int_n_i),
  .wake_pin_i(wake_pin_i), .wake_dir_out_i(wake_dir_out_i),
  .clk_en_o(clk_en_o), .gate_rd_o(gate_rd_o)
);

// File: tb/mclk_gate_ctrl_bench.sv
`timescale 1ns/1ps
module mclk_gate_ctrl_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [15:0] wr_data_i = '0;
  logic        rtc_evt_i = 1'b0;
  logic        rtc_en_i = 1'b0;
  logic [1:0]  int_n_i = 2'b11;
  logic        wake_pin_i = 1'b0;
  logic        wake_dir_out_i = 1'b0;
  logic        clk_en_o;
  logic        gate_rd_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  mclk_gate_ctrl u_mclk_gate_ctrl (.*);

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  // gate bit and enable together
  task automatic chk_gate(input string req, input logic exp);
    chk(req, gate_rd_o, exp);
    chk({req, " en"}, clk_en_o, ~exp);
  endtask

  task automatic do_write(input logic [15:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0; wr_data_i = '0;
    #2;
  endtask

  task automatic t_reset();
    #5 chk_gate("R1 in reset", 1'b0);
    @(negedge clk_i) rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk_gate("R1 after reset", 1'b0);
  endtask

  task automatic t_write();
    do_write(16'h8000);
    chk_gate("R2 gate set", 1'b1);
    @(negedge clk_i) wr_data_i = 16'h0000;
    repeat (2) @(negedge clk_i);
    chk_gate("R4 no strobe hold", 1'b1);
    do_write(16'h7FFF);
    chk_gate("R3 clear other bits set", 1'b0);
    @(negedge clk_i) wr_data_i = 16'hFFFF;
    repeat (2) @(negedge clk_i);
    wr_data_i = '0;
    chk_gate("R4 no strobe stays clear", 1'b0);
    do_write(16'h8000);
    do_write(16'h0000);
    chk_gate("R3 clear", 1'b0);
  endtask

  task automatic t_int();
    for (int i = 0; i < 2; i++) begin
      do_write(16'h8000);
      chk_gate("R2 pre int", 1'b1);
      @(posedge clk_i) #3;
      int_n_i[i] = 1'b0;
      #2 chk_gate("R5 int async wake", 1'b0);
      @(negedge clk_i) int_n_i[i] = 1'b1;
      @(negedge clk_i) chk_gate("R5 stays awake", 1'b0);
    end
  endtask

  task automatic t_pin();
    wake_dir_out_i = 1'b1;
    wake_pin_i = 1'b1;
    do_write(16'h8000);
    chk_gate("R7 disable with output pin high", 1'b1);
    repeat (2) @(negedge clk_i);
    chk_gate("R7 output pin ignored", 1'b1);
    @(posedge clk_i) #3;
    wake_dir_out_i = 1'b0;
    #2 chk_gate("R6 input pin wake", 1'b0);
    do_write(16'h8000);
    chk_gate("R9 pin high blocks disable", 1'b0);
    wake_pin_i = 1'b0;
    do_write(16'h8000);
    chk_gate("R6 pin low allows disable", 1'b1);
    do_write(16'h0000);
  endtask

  task automatic t_rtc();
    do_write(16'h8000);
    rtc_evt_i = 1'b1;
    repeat (2) @(negedge clk_i);
    chk_gate("R8 rtc disabled ignored", 1'b1);
    @(posedge clk_i) #3;
    rtc_en_i = 1'b1;
    #2 chk_gate("R8 rtc enabled wake", 1'b0);
    do_write(16'h8000);
    chk_gate("R9 rtc blocks disable", 1'b0);
    rtc_evt_i = 1'b0; rtc_en_i = 1'b0;
  endtask

  task automatic t_block();
    int_n_i = 2'b10;
    do_write(16'h8000);
    chk_gate("R9 int blocks disable", 1'b0);
    int_n_i = 2'b11;
    do_write(16'h8000);
    chk_gate("R9 disable after release", 1'b1);
  endtask

  task automatic t_async_rst();
    @(posedge clk_i) #3;
    rst_ni = 1'b0;
    #2 chk_gate("R11 reset wakes", 1'b0);
    @(negedge clk_i) rst_ni = 1'b1;
    @(negedge clk_i) chk_gate("R11 stays awake", 1'b0);
  endtask

  initial begin
    t_reset();
    t_write();
    t_int();
    t_pin();
    t_rtc();
    t_block();
    t_async_rst();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule